// File: doc/BRIEF.md
# Selectable Keyed Waveform Generator

This block synthesises a sampled carrier and keys it with a pseudo-random bit stream. Four keying schemes are available: on-off amplitude, two-tone frequency, two-phase and four-phase. All four share one phase accumulator, one sine table computed at elaboration, and one four-bit linear feedback shift register. A two-bit select input picks the scheme, and the choice is taken up only where one symbol ends and the next begins, so no symbol is ever cut short.

Each sample is built in two's complement inside the block. It leaves through a register in offset-binary form, ready for a unipolar converter that takes one code per clock. A symbol always spans a fixed number of wraps of the base carrier phase. The data register steps exactly once per symbol.

Top module: `keying_wavegen`

## Requirements
- R1: While `rstN` is low, `dacCode` is the mid-scale code 0x800. Reset also clears the phase and the wrap count, loads the shift register with `LFSR_SEED`, and selects amplitude keying whatever `modeSel` holds.
- R2: Each clock the phase advances by `BASE_INC` modulo 2^`PHASE_W`. The table is addressed by the top `LUT_ADDR_W` bits of the lookup phase. Entry i, with H half the table depth, p = i mod H and A = 2^(`SAMPLE_W`-1)-1, holds trunc(16·A·p·(H-p) / (5H² - 4p(H-p))). That value is negated when i ≥ H.
- R3: A symbol ends on the clock edge where the phase wraps for the `SYM_CYCLES`-th time since the last boundary. On that edge the register r steps to {r[2:0], r[3]^r[2]}, which is the polynomial x^4+x^3+1. It never holds zero.
- R4: The select map is 00 amplitude, 01 frequency, 10 two-phase and 11 four-phase keying. `modeSel` is sampled only on a symbol-ending edge, and changes at any other time have no effect.
- R5: Amplitude keying uses bit r[0]. A 1 gives the table sine at the plain phase, and a 0 gives a signed zero sample.
- R6: Frequency keying uses bit r[0]. A 0 looks up the plain phase, and a 1 looks up twice the phase modulo 2^`PHASE_W`.
- R7: Two-phase keying adds half a turn (2^(`PHASE_W`-1)) to the lookup phase when r[0] is 1.
- R8: Four-phase keying takes r[1:0] as its symbol. It adds 1/8 of a turn for 00, 3/8 for 01, 5/8 for 11 and 7/8 for 10.
- R9: `dacCode` is registered. One clock after a state is present, it shows that state's signed sample with the MSB inverted and the lower bits unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 2 | Keying scheme request, applied at the next symbol boundary |
| dacCode | output | SAMPLE_W | Offset-binary sample for the converter |

## Verification
The bench builds the block with an 8-bit phase, a 64-entry table and an increment of 4. One carrier period is then 64 clocks, every table entry is read, and a symbol lasts 512 clocks. With this setup, sixteen symbols per scheme cover the whole 15-state shift-register period, including every two-bit symbol and both amplitude states. The select input is also wiggled inside each symbol, and a reset is applied in mid-run.

// File: rtl/keying_pkg.sv
package keying_pkg;

  typedef enum logic [1:0] {
    MODE_AMP  = 2'b00,
    MODE_FREQ = 2'b01,
    MODE_BPH  = 2'b10,
    MODE_QPH  = 2'b11
  } keyMode_e;

  typedef struct packed {
    logic     symEdge;
    keyMode_e mode;
    logic [1:0] dataBits;
  } ctrlBus_t;

  // Rational sine approximation over one half turn, negated for the second half.
  function automatic longint sineValue(input longint idx, input longint half, input longint amp);
    longint p, num, den, mag;
    p   = (idx >= half) ? idx - half : idx;
    num = amp * 16 * p * (half - p);
    den = 5 * half * half - 4 * p * (half - p);
    mag = num / den;
    return (idx >= half) ? -mag : mag;
  endfunction

endpackage

// File: rtl/keying_sine_rom.sv
module keying_sine_rom #(
  parameter int SAMPLE_W = 12,
  parameter int ADDR_W   = 8
) (
  input  logic [ADDR_W-1:0]          rdAddr,
  output logic signed [SAMPLE_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam longint HALF = DEPTH / 2;
  localparam longint AMP  = (longint'(1) << (SAMPLE_W - 1)) - 1;

  logic signed [SAMPLE_W-1:0] table_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    assign table_q[i] = SAMPLE_W'(keying_pkg::sineValue(longint'(i), HALF, AMP));
  end

  assign rdData = table_q[rdAddr];

endmodule

// File: rtl/keying_ctrl.sv
module keying_ctrl
  import keying_pkg::*;
#(
  parameter int         SYM_CYCLES = 8,
  parameter logic [3:0] LFSR_SEED  = 4'b0001
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] selIn,
  input  logic       carrierWrap,
  output ctrlBus_t   ctrlOut
);
  localparam int CNT_W = (SYM_CYCLES > 1) ? $clog2(SYM_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST_WRAP = CNT_W'(SYM_CYCLES - 1);

  logic [CNT_W-1:0] wrapCnt;
  logic [3:0]       lfsr;
  keyMode_e         mode;
  logic             symEdge;

  assign symEdge = carrierWrap && (wrapCnt == LAST_WRAP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrapCnt <= '0;
      lfsr    <= LFSR_SEED;
      mode    <= MODE_AMP;
    end else if (carrierWrap) begin
      if (symEdge) begin
        wrapCnt <= '0;
        lfsr    <= {lfsr[2:0], lfsr[3] ^ lfsr[2]};
        mode    <= keyMode_e'(selIn);
      end else begin
        wrapCnt <= wrapCnt + 1'b1;
      end
    end
  end

  assign ctrlOut = '{symEdge: symEdge, mode: mode, dataBits: lfsr[1:0]};

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !symEdge |=> $stable(mode)); // R4
  AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !symEdge |=> $stable(lfsr)); // R3
  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    lfsr != 4'b0000); // R3
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    wrapCnt <= LAST_WRAP); // R3

endmodule

// File: rtl/keying_datapath.sv
module keying_datapath
  import keying_pkg::*;
#(
  parameter int SAMPLE_W   = 12,
  parameter int PHASE_W    = 16,
  parameter int LUT_ADDR_W = 8,
  parameter int BASE_INC   = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlBus_t            ctrlIn,
  output logic                carrierWrap,
  output logic [SAMPLE_W-1:0] sampleOut
);
  localparam logic [PHASE_W-1:0]  INC       = PHASE_W'(BASE_INC);
  localparam logic [PHASE_W-1:0]  HALF_TURN = PHASE_W'(1) << (PHASE_W - 1);
  localparam logic [PHASE_W-1:0]  EIGHTH    = PHASE_W'(1) << (PHASE_W - 3);
  localparam logic [SAMPLE_W-1:0] MIDSCALE  = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic [PHASE_W-1:0]         phase;
  logic [PHASE_W-1:0]         nextPhase;
  logic [PHASE_W-1:0]         scaledPhase;
  logic [PHASE_W-1:0]         offsetPhase;
  logic [PHASE_W-1:0]         lookPhase;
  logic [LUT_ADDR_W-1:0]      romAddr;
  logic signed [SAMPLE_W-1:0] romData;
  logic signed [SAMPLE_W-1:0] modVal;
  logic                       dataBit;

  assign {carrierWrap, nextPhase} = {1'b0, phase} + {1'b0, INC};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= '0;
    else       phase <= nextPhase;
  end

  always_comb begin
    dataBit     = ctrlIn.dataBits[0];
    scaledPhase = phase;
    offsetPhase = '0;
    unique case (ctrlIn.mode)
      MODE_FREQ: if (dataBit) scaledPhase = phase << 1;
      MODE_BPH:  if (dataBit) offsetPhase = HALF_TURN;
      MODE_QPH: begin
        case (ctrlIn.dataBits)
          2'b00:   offsetPhase = EIGHTH;
          2'b01:   offsetPhase = PHASE_W'(3) * EIGHTH;
          2'b11:   offsetPhase = PHASE_W'(5) * EIGHTH;
          default: offsetPhase = PHASE_W'(7) * EIGHTH;
        endcase
      end
      default: ;
    endcase
  end

  assign lookPhase = scaledPhase + offsetPhase;
  assign romAddr   = lookPhase[PHASE_W-1 -: LUT_ADDR_W];

  keying_sine_rom #(
    .SAMPLE_W(SAMPLE_W),
    .ADDR_W  (LUT_ADDR_W)
  ) i_rom (
    .rdAddr(romAddr),
    .rdData(romData)
  );

  assign modVal = (ctrlIn.mode == MODE_AMP && !dataBit) ? '0 : romData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sampleOut <= MIDSCALE;
    else       sampleOut <= {~modVal[SAMPLE_W-1], modVal[SAMPLE_W-2:0]};
  end

  AST_WRAP_LOW: assert property (@(posedge clk) disable iff (!rstN)
    carrierWrap |=> phase < INC); // R2
  AST_SYM_AT_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    ctrlIn.symEdge |=> phase < INC); // R3
  AST_AMP_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlIn.mode == MODE_AMP && !ctrlIn.dataBits[0]) |=> sampleOut == MIDSCALE); // R5

endmodule

// File: rtl/keying_wavegen.sv
module keying_wavegen
  import keying_pkg::*;
#(
  parameter int         SAMPLE_W   = 12,
  parameter int         PHASE_W    = 16,
  parameter int         LUT_ADDR_W = 8,
  parameter int         BASE_INC   = 64,
  parameter int         SYM_CYCLES = 8,
  parameter logic [3:0] LFSR_SEED  = 4'b0001
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          modeSel,
  output logic [SAMPLE_W-1:0] dacCode
);
  ctrlBus_t ctrlBus;
  logic     carrierWrap;

  keying_ctrl #(
    .SYM_CYCLES(SYM_CYCLES),
    .LFSR_SEED (LFSR_SEED)
  ) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .selIn      (modeSel),
    .carrierWrap(carrierWrap),
    .ctrlOut    (ctrlBus)
  );

  keying_datapath #(
    .SAMPLE_W  (SAMPLE_W),
    .PHASE_W   (PHASE_W),
    .LUT_ADDR_W(LUT_ADDR_W),
    .BASE_INC  (BASE_INC)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .ctrlIn     (ctrlBus),
    .carrierWrap(carrierWrap),
    .sampleOut  (dacCode)
  );

  AST_SEL_APPLY: assert property (@(posedge clk) disable iff (!rstN)
    ctrlBus.symEdge |=> 2'(ctrlBus.mode) == $past(modeSel)); // R4

endmodule

// File: tb/test_keying_wavegen.sv
module test_keying_wavegen;

  localparam int PW   = 8;
  localparam int AW   = 6;
  localparam int INC  = 4;
  localparam int SYMC = 8;
  localparam int SYM_LEN = SYMC * (1 << PW) / INC;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  modeSel = 2'b11;
  logic [11:0] dacCode;

  int checks = 0;
  int fails  = 0;

  int         mPhase, mCnt, mSymCount;
  logic [3:0] mLfsr;
  logic [1:0] mMode;
  bit         mFirst, mNewSym;

  always #2 clk = ~clk;

  keying_wavegen #(
    .SAMPLE_W  (12),
    .PHASE_W   (PW),
    .LUT_ADDR_W(AW),
    .BASE_INC  (INC),
    .SYM_CYCLES(SYMC),
    .LFSR_SEED (4'b0001)
  ) i_keying_wavegen (
    .clk    (clk),
    .rstN   (rstN),
    .modeSel(modeSel),
    .dacCode(dacCode)
  );

  function automatic int sineRef(int idx);
    int h, p, mag;
    h   = (1 << AW) / 2;
    p   = idx % h;
    mag = (2047 * 16 * p * (h - p)) / (5 * h * h - 4 * p * (h - p));
    return (idx >= h) ? -mag : mag;
  endfunction

  function automatic logic [11:0] refSample(int ph, logic [1:0] md, logic [3:0] lf);
    int scaled, off, look, v;
    logic [11:0] t;
    scaled = ph;
    off    = 0;
    if (md == 2'b01 && lf[0]) scaled = (ph * 2) % (1 << PW);
    if (md == 2'b10 && lf[0]) off = (1 << PW) / 2;
    if (md == 2'b11) begin
      case (lf[1:0])
        2'b00:   off = 1 * ((1 << PW) / 8);
        2'b01:   off = 3 * ((1 << PW) / 8);
        2'b11:   off = 5 * ((1 << PW) / 8);
        default: off = 7 * ((1 << PW) / 8);
      endcase
    end
    look = (scaled + off) % (1 << PW);
    v = sineRef(look >> (PW - AW));
    if (md == 2'b00 && !lf[0]) v = 0;
    t = 12'(v);
    return {~t[11], t[10:0]};
  endfunction

  function automatic string modeTag(logic [1:0] md, logic b);
    case (md)
      2'b00:   return "R5";
      2'b01:   return b ? "R6" : "R2";
      2'b10:   return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic report;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic check(string tag, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: dacCode actual 0x%03h expected 0x%03h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic resetModel;
    mPhase = 0; mCnt = 0; mSymCount = 0;
    mLfsr = 4'b0001; mMode = 2'b00;
    mFirst = 1'b1; mNewSym = 1'b0;
  endtask

  task automatic step(logic [1:0] selDrive);
    logic [11:0] exp;
    string tag;
    modeSel = selDrive;
    exp = refSample(mPhase, mMode, mLfsr);
    tag = modeTag(mMode, mLfsr[0]);
    if (selDrive != mMode) tag = "R4";
    if (mSymCount == 0 && mMode == 2'b00 && selDrive != 2'b00) tag = "R1";
    if (mNewSym) tag = "R3";
    if (mFirst) tag = "R9";
    mFirst = 1'b0;
    mNewSym = 1'b0;
    mPhase = mPhase + INC;
    if (mPhase >= (1 << PW)) begin
      mPhase = mPhase % (1 << PW);
      if (mCnt == SYMC - 1) begin
        mCnt = 0;
        mLfsr = {mLfsr[2:0], mLfsr[3] ^ mLfsr[2]};
        mMode = selDrive;
        mNewSym = 1'b1;
        mSymCount++;
      end else begin
        mCnt++;
      end
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, dacCode, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, actual running expected done");
    report();
    $finish;
  end

  initial begin
    resetModel();
    repeat (3) @(negedge clk);
    check("R1", dacCode, 12'h800);
    rstN = 1'b1;
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < 16 * SYM_LEN; c++) begin
        int pos;
        pos = c % SYM_LEN;
        if (pos >= 100 && pos < 300) step(2'(m + c));
        else step(2'(m));
      end
    end
    // Reset in mid-run, requesting two-phase keying throughout.
    modeSel = 2'b10;
    rstN = 1'b0;
    @(negedge clk);
    check("R1", dacCode, 12'h800);
    resetModel();
    rstN = 1'b1;
    for (int c = 0; c < 2 * SYM_LEN; c++) step(2'b10);
    report();
    $finish;
  end

endmodule